// File: doc/BRIEF.md
# Deferred Command / Snapshot Status Bridge for a Disc Player Bus

This block sits between a CPU I/O bus and the 8-bit parallel data bus of an external disc player. The player, not the CPU, decides when bytes move: it pulses a command strobe when it wants to take a command, and a status strobe when it presents a status byte. The CPU writes a command byte to one I/O port. The bridge stores that byte and drives it onto the player bus only while the command strobe is active. The same byte goes out again on every later command strobe until the CPU writes a new one.

While the status strobe is active the player drives a byte onto the bus. The bridge takes its snapshot of that byte when the strobe is released. A CPU read of the same port returns the latest snapshot. The start of each status strobe also gives a one-cycle request toward the non-maskable interrupt logic. Both strobes come from an asynchronous source, so each one passes through a synchroniser chain before its edges are detected.

Top module: `disc_link_port`

## Requirements
- R1: While reset is asserted and after it is released, bus_oe and nmi_req are 0, a read of the port returns 0xFF, and the held command byte is 0x00. The 0x00 appears on bus_out at the first command strobe.
- R2: A write with io_addr equal to PORT_ADDR (default 0xF4) does not drive the player bus. The byte appears on bus_out, with bus_oe high, only once a command strobe is active.
- R3: bus_oe is 1 exactly while the synchronised command strobe is low. It lags cmd_strobe_n by two clock cycles, on both the falling and the rising edge.
- R4: If the CPU writes twice before the next command strobe, the later byte replaces the earlier one, and only the later byte is driven.
- R5: The held command byte is driven again on every later command strobe until a new write replaces it.
- R6: Writes to any address other than PORT_ADDR leave the held command byte unchanged.
- R7: The status byte on bus_in is captured when the synchronised status strobe goes high again. A read during the strobe returns the previous snapshot. The new value can be read three cycles after stat_strobe_n rises.
- R8: Reads at PORT_ADDR return the latest snapshot, and repeated reads give the same value. Reads at any other address return 0x00.
- R9: nmi_req is a one-cycle pulse, two cycles after stat_strobe_n falls. There is no pulse when the strobe rises, and no pulse on any command strobe activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 8 | CPU I/O address |
| io_wr | input | 1 | CPU I/O write cycle |
| io_rd | input | 1 | CPU I/O read cycle |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | CPU read data (status snapshot, or 0x00 off-port) |
| cmd_strobe_n | input | 1 | Player command strobe, asynchronous, active low |
| stat_strobe_n | input | 1 | Player status strobe, asynchronous, active low |
| bus_in | input | 8 | Byte driven by the player |
| bus_out | output | 8 | Command byte toward the player |
| bus_oe | output | 1 | Output enable for bus_out (1 = drive) |
| nmi_req | output | 1 | Pulse on the status strobe's active edge |

## Verification
Suppose the held command byte becomes corrupted. Nothing at the ports shows it until the next command strobe has crossed the synchroniser, which takes two cycles. At that point bus_out carries the wrong byte, and it keeps carrying it on every later strobe. A fault in the status snapshot or in the edge detection is visible on the next port read, three cycles after the status strobe is released. A wrong nmi_req pulse shows up two cycles after the strobe falls.

// File: rtl/disc_link_pkg.sv
package disc_link_pkg;
   typedef struct packed {
      logic level_n;
      logic fell;
      logic rose;
   } strobe_evt_t;
endpackage

// File: rtl/dl_strobe_sync.sv
module dl_strobe_sync
   import disc_link_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strobe_n_async,
   output strobe_evt_t evt
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], strobe_n_async};
         prev_q  <= chain_q[LAST];
      end
   end

   always_comb begin
      evt.level_n = chain_q[LAST];
      evt.fell    = prev_q & ~chain_q[LAST];
      evt.rose    = ~prev_q & chain_q[LAST];
   end
endmodule

// File: rtl/dl_cmd_hold.sv
module dl_cmd_hold #(
   parameter int          DATA_W    = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              drive,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe
);
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    hold_q <= RST_VAL;
      else if (load) hold_q <= din;
   end

   assign bus_oe  = drive;
   assign bus_out = drive ? hold_q : '0;
endmodule

// File: rtl/dl_stat_capture.sv
module dl_stat_capture
   import disc_link_pkg::*;
#(
   parameter int          DATA_W       = 8,
   parameter logic [DATA_W-1:0] RST_VAL = '1,
   parameter bit          ON_RELEASE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobe_evt_t       evt,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] snap
);
   logic take;

   generate
      if (ON_RELEASE) begin : g_release
         assign take = evt.rose;
      end else begin : g_assert
         assign take = evt.fell;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    snap <= RST_VAL;
      else if (take) snap <= bus_in;
   end
endmodule

// File: rtl/disc_link_port.sv
module disc_link_port
   import disc_link_pkg::*;
#(
   parameter int DATA_W          = 8,
   parameter int ADDR_W          = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hF4,
   parameter int SYNC_STAGES     = 2,
   parameter bit CAPTURE_ON_RELEASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   input  logic              cmd_strobe_n,
   input  logic              stat_strobe_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic              nmi_req
);
   localparam logic [DATA_W-1:0] CMD_RST  = '0;
   localparam logic [DATA_W-1:0] STAT_RST = '1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   strobe_evt_t       cmd_evt, stat_evt;
   logic              hit;
   logic [DATA_W-1:0] snap;

   assign hit = (io_addr == PORT_ADDR);

   dl_strobe_sync #(.STAGES(SYNC_STAGES)) u_cmd_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n_async(cmd_strobe_n), .evt(cmd_evt));

   dl_strobe_sync #(.STAGES(SYNC_STAGES)) u_stat_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n_async(stat_strobe_n), .evt(stat_evt));

   dl_cmd_hold #(.DATA_W(DATA_W), .RST_VAL(CMD_RST)) u_cmd (
      .clk(clk), .rst_n(rst_n), .load(io_wr & hit), .din(io_wdata),
      .drive(~cmd_evt.level_n), .bus_out(bus_out), .bus_oe(bus_oe));

   dl_stat_capture #(.DATA_W(DATA_W), .RST_VAL(STAT_RST),
                     .ON_RELEASE(CAPTURE_ON_RELEASE)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt(stat_evt), .bus_in(bus_in), .snap(snap));

   assign io_rdata = (io_rd & hit) ? snap : '0;
   assign nmi_req  = stat_evt.fell;
endmodule

// File: rtl/disc_link_port_chk.sv
module disc_link_port_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 8'hF4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [DATA_W-1:0] io_rdata,
   input logic              cmd_strobe_n,
   input logic              stat_strobe_n,
   input logic [DATA_W-1:0] bus_out,
   input logic              bus_oe,
   input logic              nmi_req
);
   logic [2:0] cyc;
   always_ff @(posedge clk) begin
      if (!rst_n)         cyc <= '0;
      else if (cyc != 3'd7) cyc <= cyc + 3'd1;
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!bus_oe && !nmi_req));

   a_r3_oe_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd3) |-> (bus_oe == !$past(cmd_strobe_n, 2)));

   a_r5_drive_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $past(bus_oe) && !$past(io_wr && io_addr == PORT_ADDR))
      |-> $stable(bus_out));

   a_r9_nmi_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req && cyc >= 3'd4) |-> (!$past(stat_strobe_n, 2) && $past(stat_strobe_n, 3)));

   a_r9_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> !nmi_req);

   a_r8_off_port: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr != PORT_ADDR) |-> (io_rdata == '0));

   a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd5 && $past(stat_strobe_n, 1) && $past(stat_strobe_n, 2) &&
       $past(stat_strobe_n, 3) && $past(stat_strobe_n, 4) &&
       io_rd && io_addr == PORT_ADDR && $past(io_rd && io_addr == PORT_ADDR))
      |-> $stable(io_rdata));
endmodule

bind disc_link_port disc_link_port_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
   .io_rdata(io_rdata), .cmd_strobe_n(cmd_strobe_n), .stat_strobe_n(stat_strobe_n),
   .bus_out(bus_out), .bus_oe(bus_oe), .nmi_req(nmi_req));

// File: tb/disc_link_port_tb_top.sv
module disc_link_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] io_addr = 8'h00;
   logic       io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0] io_wdata = 8'h00;
   logic [7:0] io_rdata;
   logic       cmd_strobe_n = 1'b1, stat_strobe_n = 1'b1;
   logic [7:0] bus_in = 8'h00;
   logic [7:0] bus_out;
   logic       bus_oe, nmi_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   disc_link_port dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cmd_strobe_n(cmd_strobe_n),
      .stat_strobe_n(stat_strobe_n), .bus_in(bus_in), .bus_out(bus_out),
      .bus_oe(bus_oe), .nmi_req(nmi_req));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [7:0] a, output logic [7:0] d);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0;
   endtask

   // command strobe low for 'hold' cycles; expects byte 'exp'
   task automatic cmd_strobe(input logic [7:0] exp, input string req);
      bit saw_nmi = 1'b0;
      cmd_strobe_n = 1'b0;
      @(negedge clk);
      check(bus_oe == 1'b0, "R3", bus_oe, 0);
      @(negedge clk);
      check(bus_oe == 1'b1, "R3", bus_oe, 1);
      check(bus_out == exp, req, bus_out, exp);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         if (nmi_req) saw_nmi = 1'b1;
      end
      cmd_strobe_n = 1'b1;
      @(negedge clk);
      check(bus_oe == 1'b1, "R3", bus_oe, 1);
      @(negedge clk);
      check(bus_oe == 1'b0, "R3", bus_oe, 0);
      check(saw_nmi == 1'b0, "R9", saw_nmi, 0);
   endtask

   task automatic test_reset;
      logic [7:0] d;
      check(bus_oe == 1'b0 && nmi_req == 1'b0, "R1", {bus_oe, nmi_req}, 0);
      cpu_read(8'hF4, d);
      check(d == 8'hFF, "R1", d, 8'hFF);
      cmd_strobe(8'h00, "R1");
   endtask

   task automatic test_queue;
      cpu_write(8'hF4, 8'h3C);
      repeat (3) @(negedge clk);
      check(bus_oe == 1'b0, "R2", bus_oe, 0);
      cmd_strobe(8'h3C, "R2");
      cmd_strobe(8'h3C, "R5");
      cmd_strobe(8'h3C, "R5");
   endtask

   task automatic test_overwrite;
      cpu_write(8'hF4, 8'h11);
      cpu_write(8'hF4, 8'hA7);
      cmd_strobe(8'hA7, "R4");
   endtask

   task automatic test_other_addr;
      cpu_write(8'hF5, 8'h99);
      cpu_write(8'h74, 8'h55);
      cmd_strobe(8'hA7, "R6");
   endtask

   task automatic test_status(input logic [7:0] early, input logic [7:0] final_v,
                              input logic [7:0] prev);
      logic [7:0] d;
      bus_in = early; stat_strobe_n = 1'b0;
      @(negedge clk);
      check(nmi_req == 1'b0, "R9", nmi_req, 0);
      @(negedge clk);
      check(nmi_req == 1'b1, "R9", nmi_req, 1);
      @(negedge clk);
      check(nmi_req == 1'b0, "R9", nmi_req, 0);
      cpu_read(8'hF4, d);
      check(d == prev, "R7", d, prev);
      bus_in = final_v;
      @(negedge clk);
      stat_strobe_n = 1'b1;
      for (int i = 1; i <= 3; i++) begin
         @(negedge clk);
         check(nmi_req == 1'b0, "R9", nmi_req, 0);
      end
      bus_in = 8'h5A;
      cpu_read(8'hF4, d);
      check(d == final_v, "R7", d, final_v);
      cpu_read(8'hF4, d);
      check(d == final_v, "R8", d, final_v);
      cpu_read(8'hF3, d);
      check(d == 8'h00, "R8", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_queue();
      test_overwrite();
      test_other_addr();
      test_status(8'h10, 8'h42, 8'hFF);
      test_status(8'hC3, 8'hC3, 8'h42);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule